// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block steers a 32-bit processor core into and out of its exception handlers. It watches seven request lines: reset, undefined instruction, software interrupt, prefetch abort, data abort, normal interrupt and fast interrupt. It also watches the address of the instruction that has just completed and the current status word. When a request wins, the block saves the state and then redirects the core. It issues one write strobe per cycle, in a fixed order, towards the register file and the program counter:

1. save the old status word into the banked saved-status copy of the target mode;
2. rewrite the live status word;
3. write the return address into the target mode's link register;
4. force the program counter to the vector of that exception.

When a handler finishes, the core raises a return strobe. It supplies the cause being exited, that mode's link register and its saved status word. One cycle later the block drives the restored status word and the corrected program counter together.

Causes are carried as a 3-bit code: reset 0, undefined 1, software interrupt 2, prefetch abort 3, data abort 4, interrupt 6, fast interrupt 7. Code 5 is reserved. The vector of a cause is its code times four. Instruction decode, memory and the register file itself lie outside the block.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After rst_n is released, the block performs a reset entry on its own, without any request, and ends it by writing program counter 0x00000000.
- R2: The entry program counter is the cause code times four: 0x00 reset, 0x04 undefined, 0x08 software interrupt, 0x0C prefetch abort, 0x10 data abort, 0x18 interrupt, 0x1C fast interrupt. Address 0x14 is never written.
- R3: An entry occupies exactly four consecutive cycles, starting the cycle after the request is taken. Each cycle raises one strobe, in this order: spsr_we, cpsr_we, lr_we, pc_we.
- R4: spsr_wdata carries the status word sampled when the request was taken. spsr_mode and lr_mode carry the target mode: reset and software interrupt 5'b10011, undefined 5'b11011, both aborts 5'b10111, interrupt 5'b10010, fast interrupt 5'b10001.
- R5: During entry, cpsr_wdata keeps bits 31:8 and bit 5 of the sampled status word, places the target mode in bits 4:0 and sets bit 7. Bit 6 is set for fast interrupt and reset and is kept from the sampled word otherwise.
- R6: lr_wdata is the sampled instruction address plus 8 for interrupt, fast interrupt and data abort, and plus 4 for every other cause.
- R7: Simultaneous requests are ranked as follows: reset, data abort, fast interrupt, interrupt, prefetch abort, undefined, software interrupt.
- R8: An interrupt request is ignored while bit 7 of cur_cpsr is set. A fast interrupt request is ignored while bit 6 is set.
- R9: A non-reset request is taken only in a cycle where insn_done is high. A reset request is taken regardless of insn_done.
- R10: One cycle after ret_strobe, cpsr_we and pc_we rise together. cpsr_wdata equals ret_spsr. pc_wdata equals ret_lr minus 4 for prefetch abort, interrupt and fast interrupt, ret_lr minus 8 for data abort, and ret_lr unchanged for undefined and software interrupt.
- R11: A ret_strobe carrying cause code 0 (reset) or 5 (reserved) produces no write strobe.
- R12: While idle, a reset request outranks ret_strobe, and ret_strobe outranks all other requests. All inputs are ignored while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_rst | input | 1 | Reset request |
| req_und | input | 1 | Undefined instruction request |
| req_swi | input | 1 | Software interrupt request |
| req_pabt | input | 1 | Prefetch abort request |
| req_dabt | input | 1 | Data abort request |
| req_irq | input | 1 | Interrupt request |
| req_fiq | input | 1 | Fast interrupt request |
| insn_done | input | 1 | The current instruction completes this cycle |
| cur_pc | input | XLEN | Address of the completing instruction |
| cur_cpsr | input | XLEN | Live status word |
| ret_strobe | input | 1 | Handler exit request |
| ret_cause | input | 3 | Cause code of the exception being exited |
| ret_lr | input | XLEN | Link register of the mode being exited |
| ret_spsr | input | XLEN | Saved status word of the mode being exited |
| busy | output | 1 | Entry or return in progress |
| spsr_we | output | 1 | Saved-status write strobe |
| spsr_mode | output | 5 | Mode whose saved status is written |
| spsr_wdata | output | XLEN | Saved-status write data |
| cpsr_we | output | 1 | Status word write strobe |
| cpsr_wdata | output | XLEN | Status word write data |
| lr_we | output | 1 | Link register write strobe |
| lr_mode | output | 5 | Mode whose link register is written |
| lr_wdata | output | XLEN | Link register write data |
| pc_we | output | 1 | Program counter write strobe |
| pc_wdata | output | XLEN | Program counter write data |

## Verification
The bench builds the block with its default XLEN of 32. At that width the full vector map, the mask bits 6 and 7, and the wrap of link-register arithmetic near the top of the address space all fall within the stimulus. Random request mixes and random status words exercise the ranking and the masking together. Directed cases then cover the power-up entry, reset without insn_done, the return strobe racing a request, and returns with the reset and reserved cause codes.

// File: rtl/exc_pkg.sv
// Package: shared encodings for the exception sequencer.
// Assumes a 5-bit mode field in bits 4:0 of the status word.
package exc_pkg;

    localparam int MODE_W = 5;
    localparam int CAUSE_W = 3;
    localparam int I_BIT = 7;
    localparam int F_BIT = 6;
    localparam int NUM_REQ = 7;

    // Cause codes; the vector is the code times four.
    typedef enum logic [CAUSE_W-1:0] {
        CS_RST  = 3'd0,
        CS_UND  = 3'd1,
        CS_SWI  = 3'd2,
        CS_PABT = 3'd3,
        CS_DABT = 3'd4,
        CS_RSVD = 3'd5,
        CS_IRQ  = 3'd6,
        CS_FIQ  = 3'd7
    } cause_e;

    localparam logic [MODE_W-1:0] MD_USR = 5'b10000;
    localparam logic [MODE_W-1:0] MD_FIQ = 5'b10001;
    localparam logic [MODE_W-1:0] MD_IRQ = 5'b10010;
    localparam logic [MODE_W-1:0] MD_SVC = 5'b10011;
    localparam logic [MODE_W-1:0] MD_ABT = 5'b10111;
    localparam logic [MODE_W-1:0] MD_UND = 5'b11011;
    localparam logic [MODE_W-1:0] MD_SYS = 5'b11111;

    // Sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_SPSR = 3'd1,
        ST_CPSR = 3'd2,
        ST_LR   = 3'd3,
        ST_PC   = 3'd4,
        ST_RET  = 3'd5
    } seq_state_e;

endpackage

// File: rtl/exc_prio_arb.sv
// Module: exc_prio_arb
// Masks the interrupt requests with the status word and picks the
// highest-ranked pending request. Purely combinational.
// Assumes req bit index equals the cause code (bit 5 unused).
module exc_prio_arb
    import exc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [7:0]          req_vec,
    input  logic [XLEN-1:0]     cpsr,
    output logic                win_valid,
    output cause_e              win_cause
);
    localparam int RANKS = NUM_REQ;

    // Ranked cause list, highest first.
    localparam logic [RANKS*CAUSE_W-1:0] RANK_TBL = {
        3'd2, 3'd1, 3'd3, 3'd6, 3'd7, 3'd4, 3'd0
    };

    logic [7:0] masked;

    // Apply the I and F mask bits and drop the reserved slot.
    always_comb begin
        masked = req_vec;
        masked[CS_RSVD] = 1'b0;
        if (cpsr[I_BIT]) masked[CS_IRQ] = 1'b0;
        if (cpsr[F_BIT]) masked[CS_FIQ] = 1'b0;
    end

    logic [RANKS-1:0]   hit;
    logic [CAUSE_W-1:0] rank_cause [RANKS];

    genvar g;
    generate
        for (g = 0; g < RANKS; g++) begin : g_rank
            assign rank_cause[g] = RANK_TBL[g*CAUSE_W +: CAUSE_W];
            assign hit[g]        = masked[rank_cause[g]];
        end
    endgenerate

    // Walk the ranks from lowest to highest so the highest hit wins.
    always_comb begin
        win_valid = |hit;
        win_cause = CS_RST;
        for (int i = RANKS - 1; i >= 0; i--) begin
            if (hit[i]) win_cause = cause_e'(rank_cause[i]);
        end
    end

endmodule

// File: rtl/exc_cause_map.sv
// Module: exc_cause_map
// Translates a cause code into its target mode, vector, link offset,
// return correction and F-bit behaviour. Purely combinational.
module exc_cause_map
    import exc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  cause_e              cause,
    output logic [MODE_W-1:0]   mode,
    output logic [XLEN-1:0]     vector,
    output logic [XLEN-1:0]     lr_add,
    output logic [XLEN-1:0]     ret_sub,
    output logic                set_f,
    output logic                ret_ok
);
    localparam logic [XLEN-1:0] FOUR  = XLEN'(4);
    localparam logic [XLEN-1:0] EIGHT = XLEN'(8);

    // Vector is the cause code scaled to a word address.
    assign vector = XLEN'({cause, 2'b00});

    // Per-cause table of mode and offsets.
    always_comb begin
        mode    = MD_SVC;
        lr_add  = FOUR;
        ret_sub = '0;
        set_f   = 1'b0;
        ret_ok  = 1'b1;
        unique case (cause)
            CS_RST:  begin mode = MD_SVC; set_f = 1'b1; ret_ok = 1'b0; end
            CS_UND:  begin mode = MD_UND; end
            CS_SWI:  begin mode = MD_SVC; end
            CS_PABT: begin mode = MD_ABT; ret_sub = FOUR; end
            CS_DABT: begin mode = MD_ABT; lr_add = EIGHT; ret_sub = EIGHT; end
            CS_RSVD: begin ret_ok = 1'b0; end
            CS_IRQ:  begin mode = MD_IRQ; lr_add = EIGHT; ret_sub = FOUR; end
            CS_FIQ:  begin mode = MD_FIQ; lr_add = EIGHT; ret_sub = FOUR; set_f = 1'b1; end
            default: begin ret_ok = 1'b0; end
        endcase
    end

endmodule

// File: rtl/exc_seq.sv
// Module: exc_seq
// Four-step entry sequencer and one-step return path. It captures the
// winning cause, address and status word when idle, then steps through
// the saved-status, status, link and PC writes on successive cycles.
// Assumes a synchronous active-low reset; the first idle cycle after
// reset behaves as if reset were requested.
module exc_seq
    import exc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                win_valid,
    input  cause_e              win_cause,
    input  logic                insn_done,
    input  logic [XLEN-1:0]     cur_pc,
    input  logic [XLEN-1:0]     cur_cpsr,
    input  logic                ret_strobe,
    input  logic                ret_ok,
    input  logic [XLEN-1:0]     ret_lr,
    input  logic [XLEN-1:0]     ret_sub,
    input  logic [XLEN-1:0]     ret_spsr,
    output seq_state_e          state,
    output cause_e              cause_q,
    output logic [XLEN-1:0]     pc_q,
    output logic [XLEN-1:0]     cpsr_q,
    output logic [XLEN-1:0]     ret_pc_q,
    output logic [XLEN-1:0]     ret_cpsr_q
);
    logic       boot_q;
    logic       take_rst;
    logic       take_ret;
    logic       take_exc;
    seq_state_e state_d;

    // Decide what the idle state accepts this cycle.
    always_comb begin
        take_rst = (state == ST_IDLE) && (boot_q || (win_valid && win_cause == CS_RST));
        take_ret = (state == ST_IDLE) && !take_rst && ret_strobe && ret_ok;
        take_exc = (state == ST_IDLE) && !take_rst && !ret_strobe && win_valid && insn_done;
    end

    // Next-state selection for the fixed entry order.
    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE: begin
                if (take_rst || take_exc) state_d = ST_SPSR;
                else if (take_ret)        state_d = ST_RET;
            end
            ST_SPSR: state_d = ST_CPSR;
            ST_CPSR: state_d = ST_LR;
            ST_LR:   state_d = ST_PC;
            ST_PC:   state_d = ST_IDLE;
            ST_RET:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and boot flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            boot_q <= 1'b1;
        end else begin
            state <= state_d;
            if (take_rst) boot_q <= 1'b0;
        end
    end

    // Capture the entry context when a request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= CS_RST;
            pc_q    <= '0;
            cpsr_q  <= '0;
        end else if (take_rst || take_exc) begin
            cause_q <= take_rst ? CS_RST : win_cause;
            pc_q    <= cur_pc;
            cpsr_q  <= cur_cpsr;
        end
    end

    // Capture the corrected return values when a return is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ret_pc_q   <= '0;
            ret_cpsr_q <= '0;
        end else if (take_ret) begin
            ret_pc_q   <= ret_lr - ret_sub;
            ret_cpsr_q <= ret_spsr;
        end
    end

endmodule

// File: rtl/exc_entry_ctrl.sv
// Module: exc_entry_ctrl (top)
// Sequences exception entry and return for a core with banked modes.
// Drives write strobes for the saved-status bank, the status word, the
// banked link register and the program counter. Assumes the register
// file applies each strobe on the clock edge ending its cycle.
module exc_entry_ctrl
    import exc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_rst,
    input  logic                req_und,
    input  logic                req_swi,
    input  logic                req_pabt,
    input  logic                req_dabt,
    input  logic                req_irq,
    input  logic                req_fiq,
    input  logic                insn_done,
    input  logic [XLEN-1:0]     cur_pc,
    input  logic [XLEN-1:0]     cur_cpsr,
    input  logic                ret_strobe,
    input  logic [2:0]          ret_cause,
    input  logic [XLEN-1:0]     ret_lr,
    input  logic [XLEN-1:0]     ret_spsr,
    output logic                busy,
    output logic                spsr_we,
    output logic [4:0]          spsr_mode,
    output logic [XLEN-1:0]     spsr_wdata,
    output logic                cpsr_we,
    output logic [XLEN-1:0]     cpsr_wdata,
    output logic                lr_we,
    output logic [4:0]          lr_mode,
    output logic [XLEN-1:0]     lr_wdata,
    output logic                pc_we,
    output logic [XLEN-1:0]     pc_wdata
);
    logic [7:0]         req_vec;
    logic               win_valid;
    cause_e             win_cause;
    seq_state_e         state;
    cause_e             cause_q;
    logic [XLEN-1:0]    pc_q, cpsr_q, ret_pc_q, ret_cpsr_q;

    logic [MODE_W-1:0]  ent_mode, ret_mode_unused;
    logic [XLEN-1:0]    ent_vector, ent_lr_add, ent_ret_sub_unused;
    logic               ent_set_f, ent_ret_ok_unused;
    logic [XLEN-1:0]    rt_vector_unused, rt_lr_add_unused, rt_sub;
    logic               rt_set_f_unused, rt_ok;
    logic [XLEN-1:0]    ent_cpsr;

    // Pack requests so that bit index equals cause code.
    assign req_vec = {req_fiq, req_irq, 1'b0, req_dabt, req_pabt, req_swi, req_und, req_rst};

    exc_prio_arb #(.XLEN(XLEN)) u_arb (
        .req_vec   (req_vec),
        .cpsr      (cur_cpsr),
        .win_valid (win_valid),
        .win_cause (win_cause)
    );

    exc_cause_map #(.XLEN(XLEN)) u_ent_map (
        .cause   (cause_q),
        .mode    (ent_mode),
        .vector  (ent_vector),
        .lr_add  (ent_lr_add),
        .ret_sub (ent_ret_sub_unused),
        .set_f   (ent_set_f),
        .ret_ok  (ent_ret_ok_unused)
    );

    exc_cause_map #(.XLEN(XLEN)) u_ret_map (
        .cause   (cause_e'(ret_cause)),
        .mode    (ret_mode_unused),
        .vector  (rt_vector_unused),
        .lr_add  (rt_lr_add_unused),
        .ret_sub (rt_sub),
        .set_f   (rt_set_f_unused),
        .ret_ok  (rt_ok)
    );

    exc_seq #(.XLEN(XLEN)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .win_valid  (win_valid),
        .win_cause  (win_cause),
        .insn_done  (insn_done),
        .cur_pc     (cur_pc),
        .cur_cpsr   (cur_cpsr),
        .ret_strobe (ret_strobe),
        .ret_ok     (rt_ok),
        .ret_lr     (ret_lr),
        .ret_sub    (rt_sub),
        .ret_spsr   (ret_spsr),
        .state      (state),
        .cause_q    (cause_q),
        .pc_q       (pc_q),
        .cpsr_q     (cpsr_q),
        .ret_pc_q   (ret_pc_q),
        .ret_cpsr_q (ret_cpsr_q)
    );

    // Build the status word written on entry.
    always_comb begin
        ent_cpsr             = cpsr_q;
        ent_cpsr[MODE_W-1:0] = ent_mode;
        ent_cpsr[I_BIT]      = 1'b1;
        ent_cpsr[F_BIT]      = cpsr_q[F_BIT] | ent_set_f;
    end

    // Decode the write strobes and data from the sequencer state.
    always_comb begin
        busy       = (state != ST_IDLE);
        spsr_we    = (state == ST_SPSR);
        spsr_mode  = ent_mode;
        spsr_wdata = cpsr_q;
        cpsr_we    = (state == ST_CPSR) || (state == ST_RET);
        cpsr_wdata = (state == ST_RET) ? ret_cpsr_q : ent_cpsr;
        lr_we      = (state == ST_LR);
        lr_mode    = ent_mode;
        lr_wdata   = pc_q + ent_lr_add;
        pc_we      = (state == ST_PC) || (state == ST_RET);
        pc_wdata   = (state == ST_RET) ? ret_pc_q : ent_vector;
    end

endmodule

// File: rtl/exc_entry_ctrl_chk.sv
// Module: exc_entry_ctrl_chk
// Port-level properties of the sequencer, bound to every instance.
module exc_entry_ctrl_chk #(
    parameter int XLEN = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                spsr_we,
    input  logic [4:0]          spsr_mode,
    input  logic                cpsr_we,
    input  logic [XLEN-1:0]     cpsr_wdata,
    input  logic                lr_we,
    input  logic [4:0]          lr_mode,
    input  logic                pc_we,
    input  logic [XLEN-1:0]     pc_wdata
);
    AST_SPSR_THEN_CPSR: assert property (@(posedge clk) disable iff (!rst_n)
        spsr_we |=> (cpsr_we && !pc_we)); // R3
    AST_CPSR_THEN_LR: assert property (@(posedge clk) disable iff (!rst_n)
        (cpsr_we && !pc_we) |=> lr_we); // R3
    AST_LR_THEN_PC: assert property (@(posedge clk) disable iff (!rst_n)
        lr_we |=> (pc_we && !cpsr_we)); // R3
    AST_ONE_ENTRY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({spsr_we, lr_we, cpsr_we && !pc_we, pc_we && !cpsr_we})); // R3
    AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_we && !cpsr_we) |-> (pc_wdata[1:0] == 2'b00 && pc_wdata < XLEN'(32)
                                 && pc_wdata != XLEN'(20))); // R2
    AST_LR_MODE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        lr_we |-> (lr_mode == $past(spsr_mode, 2))); // R4
    AST_I_SET_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (cpsr_we && !pc_we) |-> cpsr_wdata[7]); // R5
    AST_MODE_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
        spsr_we |=> (cpsr_wdata[4:0] == $past(spsr_mode))); // R5
endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk #(.XLEN(XLEN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .spsr_we    (spsr_we),
    .spsr_mode  (spsr_mode),
    .cpsr_we    (cpsr_we),
    .cpsr_wdata (cpsr_wdata),
    .lr_we      (lr_we),
    .lr_mode    (lr_mode),
    .pc_we      (pc_we),
    .pc_wdata   (pc_wdata)
);

// File: tb/exc_entry_ctrl_tb.sv
// Bench for exc_entry_ctrl: directed corners plus seeded random mixes.
module exc_entry_ctrl_tb;
    localparam int XLEN = 32;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_rst = 0, req_und = 0, req_swi = 0, req_pabt = 0;
    logic req_dabt = 0, req_irq = 0, req_fiq = 0, insn_done = 0;
    logic [XLEN-1:0] cur_pc = '0, cur_cpsr = '0;
    logic ret_strobe = 0;
    logic [2:0] ret_cause = '0;
    logic [XLEN-1:0] ret_lr = '0, ret_spsr = '0;
    logic busy, spsr_we, cpsr_we, lr_we, pc_we;
    logic [4:0] spsr_mode, lr_mode;
    logic [XLEN-1:0] spsr_wdata, cpsr_wdata, lr_wdata, pc_wdata;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_entry_ctrl #(.XLEN(XLEN)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_rst(req_rst), .req_und(req_und), .req_swi(req_swi),
        .req_pabt(req_pabt), .req_dabt(req_dabt), .req_irq(req_irq),
        .req_fiq(req_fiq), .insn_done(insn_done),
        .cur_pc(cur_pc), .cur_cpsr(cur_cpsr),
        .ret_strobe(ret_strobe), .ret_cause(ret_cause),
        .ret_lr(ret_lr), .ret_spsr(ret_spsr),
        .busy(busy), .spsr_we(spsr_we), .spsr_mode(spsr_mode),
        .spsr_wdata(spsr_wdata), .cpsr_we(cpsr_we), .cpsr_wdata(cpsr_wdata),
        .lr_we(lr_we), .lr_mode(lr_mode), .lr_wdata(lr_wdata),
        .pc_we(pc_we), .pc_wdata(pc_wdata)
    );

    task automatic chk(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] mode_of(input int c);
        case (c)
            0, 2: return 5'b10011;
            1: return 5'b11011;
            3, 4: return 5'b10111;
            6: return 5'b10010;
            default: return 5'b10001;
        endcase
    endfunction

    function automatic logic [XLEN-1:0] lr_add(input int c);
        return (c == 4 || c == 6 || c == 7) ? 8 : 4;
    endfunction

    function automatic logic [XLEN-1:0] ret_sub(input int c);
        return (c == 4) ? 8 : ((c == 3 || c == 6 || c == 7) ? 4 : 0);
    endfunction

    function automatic logic [XLEN-1:0] new_cpsr(input int c, input logic [XLEN-1:0] s);
        logic [XLEN-1:0] r;
        r = s;
        r[4:0] = mode_of(c);
        r[7] = 1'b1;
        r[6] = s[6] | (c == 0 || c == 7);
        return r;
    endfunction

    // Bench model of the winner: -1 none, else cause code.
    function automatic int pick(input logic [6:0] rq, input logic dn, input logic [XLEN-1:0] s);
        if (rq[0]) return 0;
        if (!dn) return -1;
        if (rq[4]) return 4;
        if (rq[6] && !s[6]) return 7;
        if (rq[5] && !s[7]) return 6;
        if (rq[3]) return 3;
        if (rq[1]) return 1;
        if (rq[2]) return 2;
        return -1;
    endfunction

    task automatic clear_in();
        {req_rst, req_und, req_swi, req_pabt, req_dabt, req_irq, req_fiq} = '0;
        insn_done = 0;
        ret_strobe = 0;
    endtask

    // Called at the negedge where the SPSR step is visible.
    task automatic check_entry(input int c, input logic [XLEN-1:0] pc, input logic [XLEN-1:0] s);
        chk("R3 spsr step strobe", {31'b0, spsr_we}, 1);
        chk("R4 spsr mode", {27'b0, spsr_mode}, {27'b0, mode_of(c)});
        chk("R4 spsr data", spsr_wdata, s);
        @(negedge clk);
        chk("R3 cpsr step strobe", {30'b0, cpsr_we, pc_we}, 2);
        chk("R5 entry status word", cpsr_wdata, new_cpsr(c, s));
        @(negedge clk);
        chk("R3 lr step strobe", {31'b0, lr_we}, 1);
        chk("R4 lr mode", {27'b0, lr_mode}, {27'b0, mode_of(c)});
        chk("R6 link value", lr_wdata, pc + lr_add(c));
        @(negedge clk);
        chk("R3 pc step strobe", {30'b0, pc_we, cpsr_we}, 2);
        chk("R2 vector", pc_wdata, XLEN'(c * 4));
        @(negedge clk);
        chk("R3 idle after entry", {31'b0, busy}, 0);
    endtask

    // Drive one stimulus cycle and check the result against the model.
    task automatic step(input logic [6:0] rq, input logic dn, input logic [XLEN-1:0] pc,
                        input logic [XLEN-1:0] s, input logic rs, input logic [2:0] rc,
                        input logic [XLEN-1:0] lr, input logic [XLEN-1:0] sp, input string tag);
        int c;
        {req_fiq, req_irq, req_dabt, req_pabt, req_swi, req_und, req_rst} = rq;
        insn_done = dn; cur_pc = pc; cur_cpsr = s;
        ret_strobe = rs; ret_cause = rc; ret_lr = lr; ret_spsr = sp;
        @(negedge clk);
        clear_in();
        c = pick(rq, dn, s);
        if (c == 0) begin
            check_entry(0, pc, s);
        end else if (rs) begin
            if (rc == 0 || rc == 5) begin
                chk({"R11 ignored return ", tag}, {28'b0, busy, spsr_we, cpsr_we, pc_we}, 0);
            end else begin
                chk({"R10 return strobes ", tag}, {30'b0, cpsr_we, pc_we}, 3);
                chk({"R10 restored status ", tag}, cpsr_wdata, sp);
                chk({"R10 corrected pc ", tag}, pc_wdata, lr - ret_sub(int'(rc)));
                @(negedge clk);
                chk("R10 idle after return", {31'b0, busy}, 0);
            end
        end else if (c < 0) begin
            chk({"R8/R9 nothing taken ", tag}, {27'b0, busy, spsr_we, cpsr_we, lr_we, pc_we}, 0);
        end else begin
            chk({"R7 winning mode ", tag}, {27'b0, spsr_mode}, {27'b0, mode_of(c)});
            check_entry(c, pc, s);
        end
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin : main
        logic [6:0] rq;
        logic [XLEN-1:0] s;
        int seed;
        seed = 32'h5EED;
        void'($urandom(seed));
        cur_cpsr = 32'h0000_00D0;
        cur_pc = 32'h0000_1230;
        repeat (3) @(negedge clk);
        chk("R1 outputs quiet in reset", {27'b0, busy, spsr_we, cpsr_we, lr_we, pc_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: automatic reset entry after release
        check_entry(0, 32'h0000_1230, 32'h0000_00D0);

        // R7: data abort beats fast interrupt
        step(7'b1010000, 1, 32'h100, 32'h10, 0, 0, 0, 0, "dabt>fiq");
        // R7: undefined beats software interrupt
        step(7'b0000110, 1, 32'h200, 32'h10, 0, 0, 0, 0, "und>swi");
        // R8: masked interrupt alone is ignored
        step(7'b0100000, 1, 32'h300, 32'h90, 0, 0, 0, 0, "irq masked");
        // R8: masked fast interrupt falls through to interrupt
        step(7'b1100000, 1, 32'h300, 32'h50, 0, 0, 0, 0, "fiq masked");
        // R9: no insn_done, no entry
        step(7'b0001000, 0, 32'h400, 32'h10, 0, 0, 0, 0, "no done");
        // R9: reset taken without insn_done
        step(7'b0000001, 0, 32'h404, 32'h1F, 0, 0, 0, 0, "rst no done");
        // R12: return outranks an interrupt
        step(7'b0100000, 1, 32'h500, 32'h10, 1, 3'd4, 32'h508, 32'h6000_0010, "ret>irq");
        // R12: reset outranks return
        step(7'b0000001, 1, 32'h600, 32'h10, 1, 3'd6, 32'h700, 32'h10, "rst>ret");
        // R11: reserved and reset cause codes on return
        step(7'b0, 0, 0, 32'h10, 1, 3'd5, 32'h800, 32'h10, "ret rsvd");
        step(7'b0, 0, 0, 32'h10, 1, 3'd0, 32'h800, 32'h10, "ret rst");
        // R6/R10: wrap near the top of the address space
        step(7'b1000000, 1, 32'hFFFF_FFFC, 32'h10, 0, 0, 0, 0, "fiq wrap");
        step(7'b0, 0, 0, 32'h10, 1, 3'd4, 32'h0000_0004, 32'h10, "dabt wrap");

        // R12: inputs ignored while busy
        req_irq = 1; insn_done = 1; cur_pc = 32'h900; cur_cpsr = 32'h10;
        @(negedge clk);
        req_irq = 0; req_fiq = 1; ret_strobe = 1; ret_cause = 3'd6;
        chk("R12 mode held while busy", {27'b0, spsr_mode}, {27'b0, 5'b10010});
        @(negedge clk);
        chk("R12 no early pc write", {31'b0, pc_we}, 0);
        clear_in();
        repeat (3) @(negedge clk);
        chk("R12 busy cleared", {31'b0, busy}, 0);

        // Random mix of R2 R4 R5 R6 R7 R8 R10 coverage.
        for (int i = 0; i < 400; i++) begin
            rq = 7'($urandom) & 7'b1111110;
            if (($urandom % 20) == 0) rq[0] = 1'b1;
            s = $urandom;
            step(rq, 1'($urandom), {$urandom, 2'b00} >> 0, s,
                 (($urandom % 4) == 0), 3'($urandom), $urandom, $urandom, "random");
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule